// File: doc/BRIEF.md
# Tone period validator

This block decides whether a metering tone on a line channel lies inside a programmable frequency window. A level detector upstream sends a one-cycle pulse for every 32 cycles of the received tone, so the spacing between two pulses, counted in reference clock cycles, gives the tone period averaged over 32 cycles. The validator times each spacing. It compares the count with a minimum and a maximum limit, and raises a tone-valid flag after a run of correctly spaced intervals. The flag is used as-is when the channel output follows the tone envelope.

The limits come from a table indexed by the channel's frequency select (12 kHz or 16 kHz) and its 2-bit bandwidth code. The table is computed at elaboration from the reference clock rate. Each limit sits midway between the guaranteed-detect edge and the guaranteed-reject edge of the chosen band. A reset, a change of frequency or bandwidth setting, an interval outside the limits, or a silence longer than the maximum limit all clear the run.

Top module: `tone_period_validator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tone_valid_o` is 0.
- R2: An interval is the number of clock cycles between the sampling edges of two successive pulses. It is in range when MIN <= I <= MAX, with MIN = floor(N*C*10000 / (F*(10000+M))) and MAX = floor(N*C*10000 / (F*(10000-M))). Here N is PULSE_DIV, C is CLK_HZ, F is the selected frequency and M is the margin in hundredths of a percent. Both boundary values are accepted.
- R3: `tone_valid_o` rises on the clock edge that samples the pulse closing the third consecutive in-range interval (GOOD_NEEDED = 3).
- R4: A pulse closing an interval below MIN clears `tone_valid_o` on the edge that samples it and restarts the run of consecutive intervals. That pulse starts a new interval.
- R5: If no pulse arrives within MAX cycles of the previous one, `tone_valid_o` is cleared and the run is lost. The next pulse only starts timing.
- R6: Any change of `cfg_freq16_i` or `cfg_bw_i` clears `tone_valid_o` and the run on the following edge. The next pulse only starts timing.
- R7: The bandwidth code selects margin M: 00 → 2.75 %, 01 → 4.25 %, 10 → 6.25 %, 11 → 8.75 %. `cfg_freq16_i` = 1 selects 16 kHz and 0 selects 12 kHz.
- R8: Once valid, `tone_valid_o` stays 1 while further pulses keep closing in-range intervals.
- R9: The first pulse after reset does not count as an interval and leaves `tone_valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_freq16_i | input | 1 | Frequency select: 1 = 16 kHz, 0 = 12 kHz |
| cfg_bw_i | input | 2 | Bandwidth code selecting the acceptance margin |
| pulse_i | input | 1 | One-cycle pulse per 32 tone cycles from the level detector |
| tone_valid_o | output | 1 | Tone qualified within the selected window |

## Verification
The hardest situations to reach are the exact limit edges and the silence timeout. An interval one cycle past MAX never closes as a rejected interval: the validator times out on the edge before the late pulse arrives. The bench overrides the reference rate so that intervals are a few hundred cycles. It computes MIN and MAX independently for each of the eight settings and places pulses at exactly MIN, MAX, MIN-1 and MAX+1 cycles. For the silence case it samples the flag inside a gap longer than MAX, before the late pulse lands.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

   typedef logic [1:0] bw_code_t;

   // acceptance margin in hundredths of a percent, midway between detect and reject edges
   function automatic longint margin_bp(input int code);
      case (code)
         0:       return 64'd275;
         1:       return 64'd425;
         2:       return 64'd625;
         default: return 64'd875;
      endcase
   endfunction

   // interval limit in clock cycles; upper = 1 gives the longest accepted interval
   function automatic longint period_limit(input longint clk_hz, input longint pulse_div,
                                           input longint freq_hz, input int code,
                                           input bit upper);
      longint num;
      longint den;
      num = pulse_div * clk_hz * 64'd10000;
      den = upper ? freq_hz * (64'd10000 - margin_bp(code))
                  : freq_hz * (64'd10000 + margin_bp(code));
      return num / den;
   endfunction

endpackage

// File: rtl/tpv_limit_table.sv
module tpv_limit_table
   import tpv_pkg::*;
#(
   parameter int CLK_HZ    = 3579545,
   parameter int PULSE_DIV = 32,
   parameter int FREQ_LO   = 12000,
   parameter int FREQ_HI   = 16000,
   parameter int CNT_W     = 16
) (
   input  logic             freq_hi_i,
   input  bw_code_t         bw_i,
   output logic [CNT_W-1:0] min_o,
   output logic [CNT_W-1:0] max_o
);

   localparam int ENTRIES = 8;

   logic [CNT_W-1:0] tbl_min [ENTRIES];
   logic [CNT_W-1:0] tbl_max [ENTRIES];

   for (genvar idx = 0; idx < ENTRIES; idx++) begin : g_entry
      localparam longint F_SEL = (idx >= 4) ? longint'(FREQ_HI) : longint'(FREQ_LO);
      localparam longint LO    = period_limit(CLK_HZ, PULSE_DIV, F_SEL, idx % 4, 1'b0);
      localparam longint HI    = period_limit(CLK_HZ, PULSE_DIV, F_SEL, idx % 4, 1'b1);
      if (HI >= (longint'(1) << CNT_W) || LO < 2) begin : g_bad
         $error("tpv_limit_table: limit does not fit counter width");
      end
      assign tbl_min[idx] = CNT_W'(LO);
      assign tbl_max[idx] = CNT_W'(HI);
   end

   logic [2:0] sel;
   assign sel   = {freq_hi_i, bw_i};
   assign min_o = tbl_min[sel];
   assign max_o = tbl_max[sel];

endmodule

// File: rtl/tpv_interval_timer.sv
module tpv_interval_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             pulse_i,
   input  logic [CNT_W-1:0] max_i,
   output logic             strobe_o,
   output logic             timeout_o,
   output logic [CNT_W-1:0] len_o
);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   assign strobe_o  = pulse_i && armed_q && !clear_i;
   assign timeout_o = armed_q && !pulse_i && !clear_i && (cnt_q >= max_i);
   assign len_o     = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (pulse_i) begin
         armed_q <= 1'b1;
         cnt_q   <= CNT_W'(1);
      end else if (timeout_o) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (armed_q) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && !clear_i |-> cnt_q <= max_i);  // R5

   AST_SILENCE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !strobe_o || $past(pulse_i));  // R5

endmodule

// File: rtl/tpv_run_qualifier.sv
module tpv_run_qualifier #(
   parameter int CNT_W       = 16,
   parameter int GOOD_NEEDED = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             timeout_i,
   input  logic             strobe_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [CNT_W-1:0] min_i,
   input  logic [CNT_W-1:0] max_i,
   output logic             valid_o
);

   localparam int GOOD_W = $clog2(GOOD_NEEDED + 1);

   logic [GOOD_W-1:0] good_q;
   logic              in_range;

   assign in_range = (len_i >= min_i) && (len_i <= max_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i || timeout_i) begin
         good_q  <= '0;
         valid_o <= 1'b0;
      end else if (strobe_i) begin
         if (in_range) begin
            if (good_q < GOOD_W'(GOOD_NEEDED)) good_q <= good_q + 1'b1;
            valid_o <= (good_q >= GOOD_W'(GOOD_NEEDED - 1));
         end else begin
            good_q  <= '0;
            valid_o <= 1'b0;
         end
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      good_q <= GOOD_W'(GOOD_NEEDED));  // R3

   AST_VALID_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_o) |-> $past(strobe_i));  // R3

   AST_OOR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && !in_range |=> !valid_o);  // R4

   AST_TIMEOUT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_i |=> !valid_o);  // R5

   AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && strobe_i && in_range && !clear_i && !timeout_i |=> valid_o);  // R8

endmodule

// File: rtl/tone_period_validator.sv
module tone_period_validator
   import tpv_pkg::*;
#(
   parameter int CLK_HZ      = 3579545,
   parameter int PULSE_DIV   = 32,
   parameter int FREQ_LO     = 12000,
   parameter int FREQ_HI     = 16000,
   parameter int GOOD_NEEDED = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cfg_freq16_i,
   input  logic [1:0] cfg_bw_i,
   input  logic       pulse_i,
   output logic       tone_valid_o
);

   localparam longint LONGEST = period_limit(CLK_HZ, PULSE_DIV, FREQ_LO, 3, 1'b1);
   localparam int     CNT_W   = $clog2(LONGEST + 2);

   if (FREQ_HI <= FREQ_LO || FREQ_LO <= 0) begin : g_bad_freq
      $error("tone_period_validator: FREQ_HI must exceed FREQ_LO > 0");
   end
   if (PULSE_DIV < 1 || GOOD_NEEDED < 1) begin : g_bad_count
      $error("tone_period_validator: PULSE_DIV and GOOD_NEEDED must be positive");
   end

   logic [2:0]       cfg_q;
   logic             cfg_chg;
   logic [CNT_W-1:0] lim_min;
   logic [CNT_W-1:0] lim_max;
   logic             strobe;
   logic             timeout;
   logic [CNT_W-1:0] len;

   assign cfg_chg = ({cfg_freq16_i, cfg_bw_i} != cfg_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cfg_q <= 3'b000;
      else         cfg_q <= {cfg_freq16_i, cfg_bw_i};
   end

   tpv_limit_table #(
      .CLK_HZ(CLK_HZ), .PULSE_DIV(PULSE_DIV),
      .FREQ_LO(FREQ_LO), .FREQ_HI(FREQ_HI), .CNT_W(CNT_W)
   ) limits_i (
      .freq_hi_i(cfg_freq16_i),
      .bw_i     (cfg_bw_i),
      .min_o    (lim_min),
      .max_o    (lim_max)
   );

   tpv_interval_timer #(.CNT_W(CNT_W)) timer_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (cfg_chg),
      .pulse_i  (pulse_i),
      .max_i    (lim_max),
      .strobe_o (strobe),
      .timeout_o(timeout),
      .len_o    (len)
   );

   tpv_run_qualifier #(.CNT_W(CNT_W), .GOOD_NEEDED(GOOD_NEEDED)) qual_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (cfg_chg),
      .timeout_i(timeout),
      .strobe_i (strobe),
      .len_i    (len),
      .min_i    (lim_min),
      .max_i    (lim_max),
      .valid_o  (tone_valid_o)
   );

   AST_CFG_CHANGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_chg |=> !tone_valid_o);  // R6

   AST_WINDOW_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lim_min < lim_max);  // R7

endmodule

// File: tb/tone_period_validator_tb_top.sv
`timescale 1ns/1ps
module tone_period_validator_tb_top;

   localparam int CLK_HZ = 120000;
   localparam int PDIV   = 32;
   localparam int FLO    = 12000;
   localparam int FHI    = 16000;
   localparam int NEED   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       freq16 = 1'b0;
   logic [1:0] bw = 2'b00;
   logic       pulse = 1'b0;
   logic       tone_valid;

   always #2.5 clk = ~clk;

   tone_period_validator #(
      .CLK_HZ(CLK_HZ), .PULSE_DIV(PDIV), .FREQ_LO(FLO), .FREQ_HI(FHI), .GOOD_NEEDED(NEED)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_freq16_i(freq16), .cfg_bw_i(bw),
      .pulse_i(pulse), .tone_valid_o(tone_valid)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    exp_q[$];
   string req_q[$];
   int    m_armed = 0;
   int    m_good  = 0;
   int    lim_min, lim_max, nom;

   function automatic int calc_lim(bit f16, int code, bit upper);
      longint f, m, num;
      f = f16 ? FHI : FLO;
      case (code)
         0: m = 275;  1: m = 425;  2: m = 625;  default: m = 875;
      endcase
      num = longint'(PDIV) * CLK_HZ * 10000;
      return int'(num / (f * (upper ? (10000 - m) : (10000 + m))));
   endfunction

   task automatic check(bit act, bit exp, string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: tone_valid actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // driver: gap = cycles since the previous pulse was sampled
   task automatic send(int gap, string req);
      bit e;
      if (m_armed != 0 && gap > lim_max) begin m_armed = 0; m_good = 0; end
      if (m_armed == 0) begin
         m_armed = 1; m_good = 0; e = 1'b0;
      end else if (gap >= lim_min && gap <= lim_max) begin
         if (m_good < NEED) m_good++;
         e = (m_good >= NEED);
      end else begin
         m_good = 0; e = 1'b0;
      end
      repeat (gap - 1) @(negedge clk);
      exp_q.push_back(e);
      req_q.push_back(req);
      pulse = 1'b1;
      @(negedge clk);
      pulse = 1'b0;
   endtask

   task automatic send_silence(int gap);
      repeat (lim_max + 2) @(negedge clk);
      check(tone_valid, 1'b0, "R5 silence");
      repeat (gap - 1 - (lim_max + 2)) @(negedge clk);
      m_armed = 0; m_good = 0;
      exp_q.push_back(1'b0);
      req_q.push_back("R5");
      m_armed = 1;
      pulse = 1'b1;
      @(negedge clk);
      pulse = 1'b0;
   endtask

   task automatic set_cfg(bit f16, int code, string req);
      freq16 = f16;
      bw = 2'(code);
      @(negedge clk);
      @(negedge clk);
      check(tone_valid, 1'b0, req);
      m_armed = 0; m_good = 0;
      lim_min = calc_lim(f16, code, 1'b0);
      lim_max = calc_lim(f16, code, 1'b1);
      nom = PDIV * CLK_HZ / (f16 ? FHI : FLO);
   endtask

   // monitor: compare flag one half cycle after each sampled pulse
   initial begin
      forever begin
         @(posedge clk);
         if (pulse) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL scoreboard: actual unexpected pulse expected none");
            end else begin
               check(tone_valid, exp_q.pop_front(), req_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(tone_valid, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(tone_valid, 1'b0, "R1 after reset");
      set_cfg(1'b0, 0, "R6");

      // basic qualification at 12 kHz narrow band
      send(100, "R9");
      send(nom, "R3"); send(nom, "R3"); send(nom, "R3");
      send(nom, "R8"); send(nom, "R8");
      // boundaries
      send(lim_max + 1, "R5 late pulse");
      send(lim_max, "R2 max"); send(lim_min, "R2 min"); send(lim_min, "R3");
      send(lim_min - 1, "R4 short");
      send(nom, "R3"); send(nom, "R3"); send(nom, "R3");
      send_silence(2 * lim_max);
      send(nom, "R3"); send(nom, "R3"); send(nom, "R3");

      // config change drops valid
      set_cfg(1'b0, 3, "R6 cfg change");
      // wide band accepts a gap the narrow band refuses
      send(50, "R9");
      send(340, "R7"); send(340, "R7"); send(340, "R7");
      set_cfg(1'b0, 0, "R6 cfg change");
      send(50, "R9");
      send(340, "R7"); send(340, "R7"); send(340, "R7"); send(340, "R7");

      // every setting: edges of the window
      for (int i = 0; i < 8; i++) begin
         set_cfg(i[2], i % 4, "R6 sweep");
         send(50, "R9");
         send(lim_min, "R2 sweep min");
         send(lim_max, "R2 sweep max");
         send(nom, "R3 sweep");
         send(lim_min - 1, "R4 sweep");
         send(nom, "R7 sweep"); send(nom, "R7 sweep");
         send(lim_max + 1, "R5 sweep");
         send(nom, "R3 sweep");
      end

      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule